// File: doc/BRIEF.md
# Serial Addressed Register Loader

This block accepts configuration writes over a three-wire serial link: an active-low frame select, a serial clock and a serial data line. All three are brought into the system clock domain through two-flop synchronizers, and data is taken on each detected rising edge of the serial clock. Each frame carries a sequence of 8-bit units, most significant bit first. The first unit is a block mask, the second is a start address, and every later unit is a data byte.

The block mask is one-hot per destination. Three mask bits enable three correction-point memories of 208 six-bit words each, arranged as 16 by 13 points. A fourth bit enables a ten-byte timing-control register file. Every enabled destination takes the same byte at the same address in the same cycle, so one frame can fill several memories in parallel. The address starts at the programmed value and advances by one per data byte while the frame stays open. Addresses past the end of a destination are dropped for that destination only.

While a frame is open, a transfer-active flag is raised. Downstream output logic uses this flag to drive a programmed fixed level instead of the correction data.

Top module: `ser_reg_loader`

## Requirements
- R1: A frame is a sequence of 8-bit units sent most significant bit first. Unit 0 is the block mask, unit 1 is the start address, and every later unit is a data byte that produces one write.
- R2: Block mask bit 0, bit 1 and bit 2 enable `mem_we[0]`, `mem_we[1]` and `mem_we[2]`. Mask bit 3 enables `cfg_we`. Mask bits 7..4 have no effect. Several enabled destinations are written together in one cycle with one shared `wr_addr`.
- R3: The first data byte is written at the start address. Each following data byte goes to the previous address plus one. At 255 the address stops advancing and does not wrap.
- R4: A memory write happens only for addresses 0..207. `mem_wdata` carries data bits 5..0, and data bits 7..6 are dropped.
- R5: A timing-control write happens only for addresses 0..9. `cfg_wdata` carries all 8 data bits.
- R6: Frame select is active low. While it is high, the bit count and the unit position are cleared. A partial byte left at the end of a frame produces no write, and the next frame starts again from the block mask.
- R7: `xfer_active` is 1 while the synchronized frame select is low and 0 while it is high. It follows the pin within 3 system clocks.
- R8: Synchronous active-low reset forces all write strobes and `xfer_active` to 0.
- R9: Each completed data byte gives a single-cycle write strobe. The data line is taken only on serial clock rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_n | input | 1 | Frame select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdat | input | 1 | Serial data, taken on sclk rising edges |
| mem_we | output | 3 | Per-memory write strobes |
| mem_wdata | output | 6 | Memory write data |
| cfg_we | output | 1 | Timing-control register write strobe |
| cfg_wdata | output | 8 | Timing-control register write data |
| wr_addr | output | 8 | Write address shared by all destinations |
| xfer_active | output | 1 | Frame in progress flag |

## Verification
The bench sends frames with these block masks:
- a single memory, which shows each mask bit steers to its own strobe;
- all four destinations at once, which shows parallel writes and the per-destination address limits;
- only the upper mask bits set, which shows those bits are dropped.

Start addresses placed just below 208, just below 10 and at 254 test the memory limit, the register limit and the no-wrap rule. Data bytes with bits 7..6 set tell the 6-bit memory path apart from the 8-bit register path. A frame cut off after 5 bits, followed by a frame cut off partway through a data byte, shows that incomplete units are discarded and that decoding restarts from the block mask.

// File: rtl/ser_loader_pkg.sv
// Package: shared constants and types for the serial register loader.
// Assumes: frames are byte oriented; unit position is tracked per frame.
package ser_loader_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_MASK = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } unit_phase_t;
endpackage

// File: rtl/srl_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: STAGES >= 2; each bit is independent; RST_VAL is the idle level.
module srl_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], din};
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/srl_deser.sv
// Module: serial-to-byte assembler in the system clock domain.
// Assumes: inputs are already synchronized; a frame is open while cs_n_s
// is low; bits arrive MSB first on serial clock rising edges.
module srl_deser
    import ser_loader_pkg::*;
#(
    parameter int UNIT_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              dat_s,
    output logic              frame_on,
    output logic              byte_done,
    output logic [UNIT_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(UNIT_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(UNIT_W - 1);

    logic             sclk_q;
    logic             sclk_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [UNIT_W-1:0] shreg;
    logic [UNIT_W-1:0] shnext;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign shnext    = {shreg[UNIT_W-2:0], dat_s};
    assign frame_on  = ~cs_n_s;

    // Track the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Shift bits in on rising edges; emit a byte after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= shnext;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    byte_val  <= shnext;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_BITCNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == '0)); // R6

    AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(!cs_n_s && sclk_rise)); // R9
endmodule

// File: rtl/srl_frame_dec.sv
// Module: frame unit decoder: block mask, start address, then data bytes.
// Assumes: byte_done pulses once per assembled byte; the unit position
// restarts whenever the frame closes.
module srl_frame_dec
    import ser_loader_pkg::*;
#(
    parameter int MASK_W = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              wr_req,
    output logic [MASK_W-1:0] wr_mask,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

    unit_phase_t       phase;
    logic [MASK_W-1:0] mask_q;
    logic [ADDR_W-1:0] addr_q;

    // Walk through the units of a frame and issue one request per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_MASK;
            mask_q  <= '0;
            addr_q  <= '0;
            wr_req  <= 1'b0;
            wr_mask <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_req <= 1'b0;
            if (!frame_on) begin
                phase <= PH_MASK;
            end else if (byte_done) begin
                unique case (phase)
                    PH_MASK: begin
                        mask_q <= byte_val[MASK_W-1:0];
                        phase  <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        addr_q <= byte_val[ADDR_W-1:0];
                        phase  <= PH_DATA;
                    end
                    default: begin
                        wr_req  <= 1'b1;
                        wr_mask <= mask_q;
                        wr_addr <= addr_q;
                        wr_data <= byte_val;
                        if (addr_q != ADDR_TOP) addr_q <= addr_q + 1'b1;
                    end
                endcase
            end
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_on && byte_done && phase == PH_DATA && addr_q != ADDR_TOP)
        |=> (addr_q == $past(addr_q) + 1'b1)); // R3

    AST_ADDR_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q == ADDR_TOP && phase == PH_DATA) |=> (addr_q == ADDR_TOP)); // R3

    AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> $past(phase == PH_DATA && byte_done)); // R1
endmodule

// File: rtl/srl_wr_router.sv
// Module: fan a write request out to the enabled destinations, range-gated.
// Assumes: mask bits [N_MEM-1:0] select memories, bit N_MEM the register file.
module srl_wr_router
    import ser_loader_pkg::*;
#(
    parameter int N_MEM     = 3,
    parameter int MEM_DW    = 6,
    parameter int MEM_WORDS = 208,
    parameter int CFG_REGS  = 10,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [N_MEM:0]    wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [N_MEM-1:0]  mem_we,
    output logic [MEM_DW-1:0] mem_wdata,
    output logic              cfg_we,
    output logic [BYTE_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] out_addr
);
    localparam logic [ADDR_W-1:0] MEM_LIM = ADDR_W'(MEM_WORDS);
    localparam logic [ADDR_W-1:0] CFG_LIM = ADDR_W'(CFG_REGS);

    logic             mem_ok;
    logic             cfg_hit;
    logic [N_MEM-1:0] mem_hit;

    assign mem_ok  = (wr_addr < MEM_LIM);
    assign cfg_hit = wr_req & wr_mask[N_MEM] & (wr_addr < CFG_LIM);

    for (genvar i = 0; i < N_MEM; i++) begin : g_mem_sel
        assign mem_hit[i] = wr_req & wr_mask[i] & mem_ok;
    end

    // Register strobes, address and data for the destinations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= '0;
            cfg_we    <= 1'b0;
            mem_wdata <= '0;
            cfg_wdata <= '0;
            out_addr  <= '0;
        end else begin
            mem_we <= mem_hit;
            cfg_we <= cfg_hit;
            if (wr_req) begin
                mem_wdata <= wr_data[MEM_DW-1:0];
                cfg_wdata <= wr_data;
                out_addr  <= wr_addr;
            end
        end
    end

    AST_MEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |-> (out_addr < MEM_LIM)); // R4

    AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (out_addr < CFG_LIM)); // R5

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we || cfg_we) |=> !(|mem_we || cfg_we)); // R9
endmodule

// File: rtl/ser_reg_loader.sv
// Module: top of the serial addressed register loader.
// Assumes: frm_n, sclk and sdat are asynchronous to clk and much slower than it
// (each serial level held for at least 3 system clocks).
module ser_reg_loader
    import ser_loader_pkg::*;
#(
    parameter int N_MEM       = 3,
    parameter int MEM_DW      = 6,
    parameter int MEM_WORDS   = 208,
    parameter int CFG_REGS    = 10,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_n,
    input  logic              sclk,
    input  logic              sdat,
    output logic [N_MEM-1:0]  mem_we,
    output logic [MEM_DW-1:0] mem_wdata,
    output logic              cfg_we,
    output logic [BYTE_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              xfer_active
);
    localparam int MASK_W = N_MEM + 1;

    logic [2:0]        sync_out;
    logic              frame_on;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              req;
    logic [MASK_W-1:0] req_mask;
    logic [ADDR_W-1:0] req_addr;
    logic [BYTE_W-1:0] req_data;

    // Bring frame select (idle high), serial clock and data into clk domain.
    srl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({frm_n, sclk, sdat}),
        .dout (sync_out)
    );

    // Assemble serial bits into bytes.
    srl_deser #(.UNIT_W(BYTE_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sync_out[1]),
        .cs_n_s   (sync_out[2]),
        .dat_s    (sync_out[0]),
        .frame_on (frame_on),
        .byte_done(byte_done),
        .byte_val (byte_val)
    );

    // Decode mask, start address and data units.
    srl_frame_dec #(.MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_on (frame_on),
        .byte_done(byte_done),
        .byte_val (byte_val),
        .wr_req   (req),
        .wr_mask  (req_mask),
        .wr_addr  (req_addr),
        .wr_data  (req_data)
    );

    // Steer each request to the enabled, in-range destinations.
    srl_wr_router #(
        .N_MEM    (N_MEM),
        .MEM_DW   (MEM_DW),
        .MEM_WORDS(MEM_WORDS),
        .CFG_REGS (CFG_REGS),
        .ADDR_W   (ADDR_W)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (req),
        .wr_mask  (req_mask),
        .wr_addr  (req_addr),
        .wr_data  (req_data),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .out_addr (wr_addr)
    );

    assign xfer_active = frame_on;

    AST_XFER_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_active) |-> $past(frm_n, SYNC_STAGES)); // R7
endmodule

// File: tb/ser_reg_loader_tb.sv
// Scoreboard bench: frame driver queues expected writes, monitor compares.
module ser_reg_loader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdat = 1'b0;
    logic [2:0] mem_we;
    logic [5:0] mem_wdata;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [7:0] wr_addr;
    logic       xfer_active;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [2:0] q_mem[$];
    logic       q_cfg[$];
    logic [7:0] q_addr[$];
    logic [7:0] q_data[$];
    string      q_tag[$];
    logic [7:0] tx_q[$];

    always #10 clk = ~clk;

    ser_reg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sclk(sclk), .sdat(sdat),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .wr_addr(wr_addr), .xfer_active(xfer_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdat = v[i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(1);
        end
    endtask

    // Send one frame from tx_q and queue the writes the requirements predict.
    task automatic run_frame(input logic [7:0] mask, input logic [7:0] sub,
                             input string tag);
        logic [7:0] a;
        logic [2:0] m;
        logic       c;
        a = sub;
        frm_n = 1'b0;
        wait_clk(4);
        chk(xfer_active == 1'b1, "R7 xfer_active in frame", xfer_active, 1);
        send_bits(mask, 8);
        send_bits(sub, 8);
        foreach (tx_q[k]) begin
            m = mask[2:0] & ((a < 8'd208) ? 3'b111 : 3'b000);
            c = mask[3] && (a < 8'd10);
            if (m != 3'b000 || c) begin
                q_mem.push_back(m);
                q_cfg.push_back(c);
                q_addr.push_back(a);
                q_data.push_back(tx_q[k]);
                q_tag.push_back(tag);
            end
            send_bits(tx_q[k], 8);
            if (a != 8'hFF) a = a + 8'd1;
        end
        wait_clk(4);
        frm_n = 1'b1;
        wait_clk(8);
        chk(xfer_active == 1'b0, "R7 xfer_active after frame", xfer_active, 0);
        chk(q_mem.size() == 0, {tag, " all expected writes seen"}, q_mem.size(), 0);
        tx_q.delete();
    endtask

    // Monitor: compare every strobe against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (|mem_we || cfg_we)) begin
            if (q_mem.size() == 0) begin
                chk(1'b0, "R2 unexpected write strobe", {mem_we, cfg_we}, 0);
            end else begin
                logic [2:0] em;
                logic       ec;
                logic [7:0] ea;
                logic [7:0] ed;
                string      t;
                em = q_mem.pop_front();
                ec = q_cfg.pop_front();
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                t  = q_tag.pop_front();
                chk(mem_we == em, {t, " R2 mem_we"}, mem_we, em);
                chk(cfg_we == ec, {t, " R2 cfg_we"}, cfg_we, ec);
                chk(wr_addr == ea, {t, " R3 wr_addr"}, wr_addr, ea);
                if (em != 3'b000)
                    chk(mem_wdata == ed[5:0], {t, " R4 mem_wdata"}, mem_wdata, ed[5:0]);
                if (ec)
                    chk(cfg_wdata == ed, {t, " R5 cfg_wdata"}, cfg_wdata, ed);
            end
        end
    end

    initial begin
        wait_clk(3);
        chk(mem_we == 3'b000 && cfg_we == 1'b0, "R8 strobes in reset", {mem_we, cfg_we}, 0);
        chk(xfer_active == 1'b0, "R8 xfer_active in reset", xfer_active, 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk(xfer_active == 1'b0, "R8 idle after reset", xfer_active, 0);

        // R1 R2: single memory, then another memory, several bytes.
        tx_q = '{8'h12, 8'h25, 8'h3F};
        run_frame(8'h01, 8'h05, "R1");
        tx_q = '{8'h0A, 8'h15};
        run_frame(8'h04, 8'h40, "R2 mem2");
        // R2 R4 R5: all destinations, crossing the register limit at 10.
        tx_q = '{8'hC5, 8'h81, 8'h7E, 8'hFF};
        run_frame(8'h0F, 8'h08, "R5 all blocks");
        // R2: upper mask bits have no effect.
        tx_q = '{8'h33, 8'h44};
        run_frame(8'hF0, 8'h02, "R2 upper mask");
        // R4: memory end at 207.
        tx_q = '{8'hE1, 8'h22, 8'h23};
        run_frame(8'h02, 8'd206, "R4 mem limit");
        // R3: address holds at 255, no wrap into range.
        tx_q = '{8'h01, 8'h02, 8'h03, 8'h04};
        run_frame(8'h0F, 8'hFE, "R3 saturate");
        // R6: partial frame of 5 bits, then a frame cut inside a data byte.
        frm_n = 1'b0;
        wait_clk(4);
        send_bits(8'h0F, 5);
        wait_clk(4);
        frm_n = 1'b1;
        wait_clk(8);
        chk(q_mem.size() == 0, "R6 partial unit ignored", q_mem.size(), 0);
        q_mem.push_back(3'b001); q_cfg.push_back(1'b0);
        q_addr.push_back(8'h30); q_data.push_back(8'h2A); q_tag.push_back("R6 restart");
        frm_n = 1'b0;
        wait_clk(4);
        send_bits(8'h01, 8);
        send_bits(8'h30, 8);
        send_bits(8'h2A, 8);
        send_bits(8'hFF, 3);
        wait_clk(4);
        frm_n = 1'b1;
        wait_clk(10);
        chk(q_mem.size() == 0, "R6 full byte written, partial dropped", q_mem.size(), 0);
        // R9: register path only, single pulses per byte.
        tx_q = '{8'h5A, 8'hA5};
        run_frame(8'h08, 8'h00, "R9 cfg only");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule